// File: doc/BRIEF.md
# Rotated Spatial Footprint Trainer

This block learns which cache blocks of a 4 KB region a program touches once a given instruction has started using that region, and replays that footprint when the same instruction starts on a fresh region. Each region is made of 64 blocks of 64 bytes. A generation starts with the first access to a region not yet tracked (the trigger). Later accesses to the same region add their blocks to the region's footprint in an accumulation table. The footprint is stored rotated so that the trigger block always sits at bit 63. Patterns learned at one trigger offset therefore apply at any other offset.

A generation ends in one of two ways: the accumulation entry is displaced by a newer region, or the cache reports the eviction of a block that is already in the footprint. The finished footprint then trains a pattern table keyed by the trigger PC, but only if it holds more than one block. Any earlier pattern for that PC is dropped first. Four independent copies of both tables exist, and a 2-bit class input picks one of them. The requester supplies the class.

On every new trigger the pattern table is looked up. A hit produces a region base and a 64-bit mask of target blocks, offered on a ready/valid port. Targets that match an outstanding miss address are removed from the mask. The cache-eviction check walks the four table copies one per cycle, and new accesses wait while it runs. The block does not send requests to memory.

Top module: `sfp_learner`

## Requirements
- R1: After reset, pred_valid is low and both acc_ready and ev_ready are high. All tables are empty, so the first trigger for any PC and class produces no prediction.
- R2: An accepted access that misses the accumulation table starts a generation. The trigger block is recorded at footprint bit 63 with a rotation of 63 minus its offset (offset = address bits [11:6]). The pattern table is searched for the (class, PC) pair, and a hit with a non-empty mask sets pred_valid in the cycle after the acceptance edge.
- R3: An accepted access that hits the accumulation table (same class, same region = address bits above bit 11) sets footprint bit (offset + rotation) mod 64. It produces no prediction.
- R4: Each accumulation set has two ways with least-recently-used replacement, and the set is given by address bits [17:12]. Inserting into a full set displaces the least recently used entry, which ends that entry's generation and trains the pattern table with its footprint.
- R5: For a stored footprint bit j below 63 and a trigger offset t, the target mask carries bit (j + t + 1) mod 64. Stored bit 63, which is the trigger block itself, never appears. pred_base is the trigger's region address with bits [11:0] zero.
- R6: When a generation ends, any pattern already stored for its PC in that class is removed. The footprint is stored only if it has two or more bits set, so a single-block generation leaves the PC with no prediction.
- R7: A cache eviction whose block lies in the footprint of an active region in any class ends that generation and trains with it. An eviction of a block outside the footprint leaves the entry and the pattern table unchanged.
- R8: The four classes keep separate tables, so a pattern learned under one class is never returned for another.
- R9: Target blocks whose region and offset match a valid outstanding-miss address are cleared from the mask. If no target remains, no prediction is offered.
- R10: While pred_valid is high and pred_ready is low, pred_base and pred_mask hold steady and acc_ready and ev_ready are low. An accepted eviction stalls both inputs for four cycles. A pending eviction takes priority and forces acc_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Demand access present |
| acc_ready | output | 1 | Access accepted when high together with acc_valid |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_pc | input | PC_W | Instruction address of the access |
| acc_cls | input | 2 | Table copy (timing class) for this access |
| ev_valid | input | 1 | Cache block eviction present |
| ev_ready | output | 1 | Eviction accepted when high together with ev_valid |
| ev_addr | input | ADDR_W | Byte address of the evicted block |
| mshr_valid | input | MSHR_N | Valid flags of outstanding misses |
| mshr_addr | input | MSHR_N*ADDR_W | Outstanding miss addresses, entry n at bits [n*ADDR_W +: ADDR_W] |
| pred_valid | output | 1 | Prediction available |
| pred_ready | input | 1 | Consumer takes the prediction |
| pred_base | output | ADDR_W | Region base of the prediction |
| pred_mask | output | 64 | Target blocks within the region |

## Verification
The bench sweeps every trigger offset against one learned pattern whose bits sit on both sides of the trigger. A rotation or wrap error would show up as targets shifted by one or as missing targets at offsets 0 and 63. It ends generations both by set conflict and by cache eviction. A wrong least-recently-used choice would displace the wrong region, and a footprint-bit test done without rotation would either ignore the eviction of a real footprint block or end a generation on an unrelated one. A single-block generation that follows a learned one must wipe the old pattern, and a design that skipped the erase would keep predicting. Outstanding-miss filtering is checked in the same region and in a different region, and the case where every target is filtered must produce no output at all.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int REGION_SHIFT = 12;
  localparam int BLK_SHIFT    = 6;
  localparam int OFF_W        = REGION_SHIFT - BLK_SHIFT;
  localparam int FOOT_W       = 1 << OFF_W;

  typedef logic [FOOT_W-1:0] foot_t;
  typedef logic [OFF_W-1:0]  off_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_OUT, ST_SCAN} st_e;

  // true when at least two bits are set
  function automatic logic multi_bit(input foot_t p);
    return |(p & (p - foot_t'(1)));
  endfunction
endpackage

// File: rtl/sfp_acc_table.sv
module sfp_acc_table
  import sfp_pkg::*;
#(
  parameter int N_CLS = 4,
  parameter int SETS  = 64,
  parameter int TAG_W = 14,
  parameter int PC_W  = 32,
  localparam int CW    = $clog2(N_CLS),
  localparam int SW    = $clog2(SETS),
  localparam int IW    = CW + SW,
  localparam int DEPTH = N_CLS * SETS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    lk_cls,
  input  logic [SW-1:0]    lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  off_t             lk_off,
  input  logic             do_access,
  input  logic [PC_W-1:0]  acc_pc,
  input  logic             do_kill,
  output logic             hit,
  output logic             hit_bit_set,
  output logic [PC_W-1:0]  hit_pc,
  output foot_t            hit_pat,
  output logic             vic_valid,
  output logic [PC_W-1:0]  vic_pc,
  output foot_t            vic_pat
);
  logic [TAG_W-1:0] tag_m [2][DEPTH];
  logic [PC_W-1:0]  pc_m  [2][DEPTH];
  off_t             rot_m [2][DEPTH];
  foot_t            pat_m [2][DEPTH];
  logic [DEPTH-1:0] vld   [2];
  logic [DEPTH-1:0] lru;

  logic [IW-1:0] idx;
  logic [1:0]    way_v, way_m;
  logic          hway, vway;
  off_t          nbit;

  assign idx = {lk_cls, lk_set};

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      way_v[w] = vld[w][idx];
      way_m[w] = way_v[w] && (tag_m[w][idx] == lk_tag);
    end
    hit         = |way_m;
    hway        = way_m[1];
    vway        = !way_v[0] ? 1'b0 : (!way_v[1] ? 1'b1 : lru[idx]);
    hit_pat     = pat_m[hway][idx];
    hit_pc      = pc_m[hway][idx];
    nbit        = off_t'(lk_off + rot_m[hway][idx]);
    hit_bit_set = hit && hit_pat[nbit];
    vic_valid   = way_v[vway];
    vic_pc      = pc_m[vway][idx];
    vic_pat     = pat_m[vway][idx];
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (do_access) begin
      if (hit) begin
        pat_m[hway][idx] <= hit_pat | (foot_t'(1) << nbit);
      end else begin
        tag_m[vway][idx] <= lk_tag;
        pc_m[vway][idx]  <= acc_pc;
        rot_m[vway][idx] <= ~lk_off;
        pat_m[vway][idx] <= foot_t'(1) << (FOOT_W - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld[0] <= '0;
      vld[1] <= '0;
      lru    <= '0;
    end else if (do_access) begin
      if (hit) begin
        lru[idx] <= ~hway;
      end else begin
        vld[vway][idx] <= 1'b1;
        lru[idx]       <= ~vway;
      end
    end else if (do_kill && hit) begin
      vld[hway][idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/sfp_pat_table.sv
module sfp_pat_table
  import sfp_pkg::*;
#(
  parameter int N_CLS = 4,
  parameter int SETS  = 256,
  parameter int TAG_W = 14,
  parameter int PC_W  = 32,
  localparam int CW    = $clog2(N_CLS),
  localparam int SW    = $clog2(SETS),
  localparam int IW    = CW + SW,
  localparam int DEPTH = N_CLS * SETS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   cls,
  input  logic [PC_W-1:0] key,
  input  logic            trn_en,
  input  foot_t           trn_pat,
  input  logic            touch,
  output logic            lk_hit,
  output foot_t           lk_pat
);
  logic [TAG_W-1:0] tag_m [2][DEPTH];
  foot_t            pat_m [2][DEPTH];
  logic [DEPTH-1:0] vld   [2];
  logic [DEPTH-1:0] lru;

  logic [IW-1:0]    idx;
  logic [TAG_W-1:0] ktag;
  logic [1:0]       way_v, way_m;
  logic             hway, wway, keep;
  logic             unused_key;

  assign idx        = {cls, key[SW-1:0]};
  assign ktag       = key[SW +: TAG_W];
  assign unused_key = ^key[PC_W-1:SW+TAG_W];
  assign keep       = multi_bit(trn_pat);

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      way_v[w] = vld[w][idx];
      way_m[w] = way_v[w] && (tag_m[w][idx] == ktag);
    end
    lk_hit = |way_m;
    hway   = way_m[1];
    lk_pat = pat_m[hway][idx];
    // an old entry for the key is overwritten in place, which erases it first
    wway   = lk_hit ? hway : (!way_v[0] ? 1'b0 : (!way_v[1] ? 1'b1 : lru[idx]));
  end

  always_ff @(posedge clk) begin
    if (trn_en && keep) begin
      tag_m[wway][idx] <= ktag;
      pat_m[wway][idx] <= trn_pat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld[0] <= '0;
      vld[1] <= '0;
      lru    <= '0;
    end else if (trn_en) begin
      if (keep) begin
        vld[wway][idx] <= 1'b1;
        lru[idx]       <= ~wway;
      end else if (lk_hit) begin
        vld[hway][idx] <= 1'b0;
      end
    end else if (touch && lk_hit) begin
      lru[idx] <= ~hway;
    end
  end
endmodule

// File: rtl/sfp_target_gen.sv
module sfp_target_gen
  import sfp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MSHR_N = 4,
  localparam int RW    = ADDR_W - REGION_SHIFT
) (
  input  foot_t                    pat,
  input  off_t                     trig,
  input  logic [RW-1:0]            region,
  input  logic [MSHR_N-1:0]        mshr_valid,
  input  logic [MSHR_N*ADDR_W-1:0] mshr_addr,
  output foot_t                    mask
);
  foot_t raw;
  logic [MSHR_N*BLK_SHIFT-1:0] unused_lo;

  // target k comes from stored bit (k - t - 1) mod 64; k == t is the trigger
  for (genvar k = 0; k < FOOT_W; k++) begin : g_rot
    assign raw[k] = (off_t'(k) != trig) && pat[off_t'(off_t'(k) + ~trig)];
  end

  for (genvar n = 0; n < MSHR_N; n++) begin : g_lo
    assign unused_lo[n*BLK_SHIFT +: BLK_SHIFT] = mshr_addr[n*ADDR_W +: BLK_SHIFT];
  end

  always_comb begin
    mask = raw;
    for (int n = 0; n < MSHR_N; n++) begin
      if (mshr_valid[n] && (mshr_addr[n*ADDR_W+REGION_SHIFT +: RW] == region))
        mask[mshr_addr[n*ADDR_W+BLK_SHIFT +: OFF_W]] = 1'b0;
    end
  end
endmodule

// File: rtl/sfp_learner.sv
module sfp_learner
  import sfp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PC_W      = 32,
  parameter int N_CLS     = 4,
  parameter int AGT_SETS  = 64,
  parameter int PHT_SETS  = 256,
  parameter int PHT_TAG_W = 14,
  parameter int MSHR_N    = 4,
  localparam int CW       = $clog2(N_CLS),
  localparam int AW       = $clog2(AGT_SETS),
  localparam int ATAG_W   = ADDR_W - REGION_SHIFT - AW,
  localparam int RW       = ADDR_W - REGION_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_valid,
  output logic                     acc_ready,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [PC_W-1:0]          acc_pc,
  input  logic [CW-1:0]            acc_cls,
  input  logic                     ev_valid,
  output logic                     ev_ready,
  input  logic [ADDR_W-1:0]        ev_addr,
  input  logic [MSHR_N-1:0]        mshr_valid,
  input  logic [MSHR_N*ADDR_W-1:0] mshr_addr,
  output logic                     pred_valid,
  input  logic                     pred_ready,
  output logic [ADDR_W-1:0]        pred_base,
  output foot_t                    pred_mask
);
  st_e               st;
  logic [PC_W-1:0]   l_pc;
  logic [CW-1:0]     l_cls, scan_cls;
  logic [RW-1:0]     l_region;
  off_t              l_off;
  logic [ADDR_W-1:0] l_ev;

  logic              acc_fire, ev_fire, in_scan;
  logic [ADDR_W-1:0] lk_addr;
  logic [CW-1:0]     lk_cls;
  logic              unused_lo;

  logic              a_hit, a_bit, a_vv;
  logic [PC_W-1:0]   a_hpc, a_vpc;
  foot_t             a_hpat, a_vpat;

  logic              p_trn, p_hit;
  logic [CW-1:0]     p_cls;
  logic [PC_W-1:0]   p_key;
  foot_t             p_pat, p_lk, tgt_mask;

  assign acc_ready = (st == ST_IDLE) && !ev_valid;
  assign ev_ready  = (st == ST_IDLE);
  assign acc_fire  = acc_valid && acc_ready;
  assign ev_fire   = ev_valid && ev_ready;
  assign in_scan   = (st == ST_SCAN);
  assign lk_addr   = in_scan ? l_ev : acc_addr;
  assign lk_cls    = in_scan ? scan_cls : acc_cls;
  assign unused_lo = ^lk_addr[BLK_SHIFT-1:0];

  sfp_acc_table #(
    .N_CLS(N_CLS), .SETS(AGT_SETS), .TAG_W(ATAG_W), .PC_W(PC_W)
  ) agt_i (
    .clk(clk), .rst(rst),
    .lk_cls(lk_cls),
    .lk_set(lk_addr[REGION_SHIFT +: AW]),
    .lk_tag(lk_addr[REGION_SHIFT+AW +: ATAG_W]),
    .lk_off(lk_addr[BLK_SHIFT +: OFF_W]),
    .do_access(acc_fire), .acc_pc(acc_pc),
    .do_kill(in_scan && a_bit),
    .hit(a_hit), .hit_bit_set(a_bit), .hit_pc(a_hpc), .hit_pat(a_hpat),
    .vic_valid(a_vv), .vic_pc(a_vpc), .vic_pat(a_vpat)
  );

  // pattern table port: training from a finished generation, else lookup
  always_comb begin
    p_trn = 1'b0;
    p_cls = l_cls;
    p_key = l_pc;
    p_pat = a_vpat;
    if (acc_fire && !a_hit && a_vv) begin
      p_trn = 1'b1;
      p_cls = acc_cls;
      p_key = a_vpc;
    end else if (in_scan && a_bit) begin
      p_trn = 1'b1;
      p_cls = scan_cls;
      p_key = a_hpc;
      p_pat = a_hpat;
    end
  end

  sfp_pat_table #(
    .N_CLS(N_CLS), .SETS(PHT_SETS), .TAG_W(PHT_TAG_W), .PC_W(PC_W)
  ) pht_i (
    .clk(clk), .rst(rst), .cls(p_cls), .key(p_key),
    .trn_en(p_trn), .trn_pat(p_pat), .touch(st == ST_LOOK),
    .lk_hit(p_hit), .lk_pat(p_lk)
  );

  sfp_target_gen #(.ADDR_W(ADDR_W), .MSHR_N(MSHR_N)) tgt_i (
    .pat(p_lk), .trig(l_off), .region(l_region),
    .mshr_valid(mshr_valid), .mshr_addr(mshr_addr), .mask(tgt_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      pred_valid <= 1'b0;
      pred_base  <= '0;
      pred_mask  <= '0;
      scan_cls   <= '0;
      l_pc       <= '0;
      l_cls      <= '0;
      l_region   <= '0;
      l_off      <= '0;
      l_ev       <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ev_fire) begin
            l_ev     <= ev_addr;
            scan_cls <= '0;
            st       <= ST_SCAN;
          end else if (acc_fire && !a_hit) begin
            l_pc     <= acc_pc;
            l_cls    <= acc_cls;
            l_region <= acc_addr[ADDR_W-1:REGION_SHIFT];
            l_off    <= acc_addr[BLK_SHIFT +: OFF_W];
            st       <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (p_hit && |tgt_mask) begin
            pred_valid <= 1'b1;
            pred_base  <= {l_region, {REGION_SHIFT{1'b0}}};
            pred_mask  <= tgt_mask;
            st         <= ST_OUT;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_OUT: begin
          if (pred_ready) begin
            pred_valid <= 1'b0;
            st         <= ST_IDLE;
          end
        end
        ST_SCAN: begin
          if (scan_cls == CW'(N_CLS - 1)) st <= ST_IDLE;
          else scan_cls <= scan_cls + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfp_learner_chk.sv
module sfp_learner_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              pred_valid,
  input logic              pred_ready,
  input logic [ADDR_W-1:0] pred_base,
  input logic [63:0]       pred_mask
);
  // R10
  hold_pred_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid && !pred_ready |=> pred_valid && $stable(pred_base) && $stable(pred_mask));

  // R10
  stall_inputs_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> !acc_ready && !ev_ready);

  // R10
  scan_stall_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid && ev_ready |=> !acc_ready && !ev_ready);

  // R9
  nonempty_mask_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> pred_mask != 64'd0);

  // R5
  region_align_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> pred_base[11:0] == 12'd0);

  // R2
  pred_latency_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_ready |=> !pred_valid);
endmodule

bind sfp_learner sfp_learner_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .pred_valid(pred_valid),
  .pred_ready(pred_ready), .pred_base(pred_base), .pred_mask(pred_mask)
);

// File: tb/sfp_learner_tb.sv
`timescale 1ns/1ps
module sfp_learner_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_ready;
  logic [31:0] acc_addr = '0, acc_pc = '0;
  logic [1:0]  acc_cls = '0;
  logic        ev_valid = 1'b0, ev_ready;
  logic [31:0] ev_addr = '0;
  logic [3:0]  mshr_valid = '0;
  logic [127:0] mshr_addr = '0;
  logic        pred_valid, pred_ready = 1'b1;
  logic [31:0] pred_base;
  logic [63:0] pred_mask;

  int n_chk = 0, n_fail = 0;

  localparam logic [31:0] PC_A = 32'h1000_0011, PC_B = 32'h1000_0022,
                          PC_C = 32'h1000_0033, PC_E = 32'h1000_0044,
                          PC_G = 32'h1000_0055, PC_S = 32'h1000_0066;

  always #10 clk = ~clk;

  sfp_learner dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_pc(acc_pc), .acc_cls(acc_cls),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
    .mshr_valid(mshr_valid), .mshr_addr(mshr_addr),
    .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_base(pred_base), .pred_mask(pred_mask)
  );

  function automatic logic [31:0] baddr(input int rn, input int off);
    return (32'(rn) << 12) | (32'(off) << 6);
  endfunction

  function automatic logic [63:0] b(input int k);
    return 64'd1 << (k % 64);
  endfunction

  task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_acc(input int rn, input int off, input logic [31:0] pc, input logic [1:0] c);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1'b1; acc_addr = baddr(rn, off); acc_pc = pc; acc_cls = c;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic do_ev(input int rn, input int off);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1'b1; ev_addr = baddr(rn, off);
    @(posedge clk); #1;
    ev_valid = 1'b0;
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
  endtask

  // sample after the edge that follows the acceptance edge
  task automatic expect_pred(input logic ev, input int rn, input logic [63:0] em, input string rq);
    logic [31:0] eb;
    eb = baddr(rn, 0);
    @(posedge clk); @(negedge clk);
    n_chk++;
    if (pred_valid !== ev || (ev && (pred_base !== eb || pred_mask !== em))) begin
      n_fail++;
      $display("FAIL %s: actual valid=%0b base=%h mask=%h expected valid=%0b base=%h mask=%h",
               rq, pred_valid, pred_base, pred_mask, ev, eb, em);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk(pred_valid == 1'b0, "R1 pred_valid", 64'(pred_valid), 64'd0);
    chk(acc_ready && ev_ready, "R1 ready", {62'd0, acc_ready, ev_ready}, 64'd3);

    // class 0: learn pc A by set conflict
    do_acc(1, 5, PC_A, 0);   expect_pred(0, 1, 0, "R1 first trigger");
    do_acc(1, 7, PC_A, 0);   expect_pred(0, 1, 0, "R3 hit no lookup");
    do_acc(1, 10, PC_A, 0);  expect_pred(0, 1, 0, "R3 hit no lookup");
    do_acc(65, 0, PC_B, 0);  expect_pred(0, 65, 0, "R2 untrained pc");
    do_acc(129, 0, PC_C, 0); expect_pred(0, 129, 0, "R4 victim trains A not C");
    do_acc(2, 20, PC_A, 0);  expect_pred(1, 2, b(22) | b(25), "R4 R5 learned pattern");
    do_acc(3, 62, PC_A, 0);  expect_pred(1, 3, b(0) | b(3), "R5 wrap");

    // R8: class 1 is separate
    do_acc(4, 20, PC_A, 1);  expect_pred(0, 4, 0, "R8 other class");

    // R9: outstanding-miss filter
    mshr_valid = 4'b0011;
    mshr_addr[31:0]  = baddr(5, 25);
    mshr_addr[63:32] = baddr(99, 22);
    do_acc(5, 20, PC_A, 0);  expect_pred(1, 5, b(22), "R9 filter same region only");
    mshr_addr[31:0]  = baddr(7, 25);
    mshr_addr[63:32] = baddr(7, 22);
    do_acc(7, 20, PC_A, 0);  expect_pred(0, 7, 0, "R9 all filtered");
    mshr_valid = 4'b0000;

    // R10: hold while consumer not ready
    pred_ready = 1'b0;
    do_acc(8, 20, PC_A, 0);  expect_pred(1, 8, b(22) | b(25), "R10 offered");
    chk(!acc_ready && !ev_ready, "R10 stall", {62'd0, acc_ready, ev_ready}, 64'd0);
    repeat (3) @(negedge clk);
    chk(pred_valid && pred_mask == (b(22) | b(25)), "R10 held", pred_mask, b(22) | b(25));
    pred_ready = 1'b1;
    @(negedge clk);
    chk(pred_valid == 1'b0, "R10 release", 64'(pred_valid), 64'd0);

    // R4: least recently used way is displaced
    do_acc(65, 3, PC_A, 0);  expect_pred(0, 65, 0, "R4 recent entry kept");
    do_acc(1, 5, PC_A, 0);   expect_pred(1, 1, b(7) | b(10), "R4 old entry gone");

    // R10: eviction priority
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = baddr(900, 0);
    #1;
    chk(acc_ready == 1'b0, "R10 eviction priority", 64'(acc_ready), 64'd0);
    @(posedge clk); #1;
    ev_valid = 1'b0;
    @(negedge clk);
    chk(acc_ready == 1'b0, "R10 scan stall", 64'(acc_ready), 64'd0);
    while (!acc_ready) @(negedge clk);

    // R7: cache eviction ends a generation (class 2)
    do_acc(10, 3, PC_E, 2);  expect_pred(0, 10, 0, "R7 setup");
    do_acc(10, 9, PC_E, 2);  expect_pred(0, 10, 0, "R3 add");
    do_ev(10, 40);
    do_acc(11, 0, PC_E, 2);  expect_pred(0, 11, 0, "R7 unrelated eviction ignored");
    do_ev(10, 9);
    do_acc(12, 30, PC_E, 2); expect_pred(1, 12, b(36), "R7 trained by eviction");
    do_acc(10, 3, PC_E, 2);  expect_pred(1, 10, b(9), "R7 entry removed");

    // R6: single-block generation erases the pattern (class 3)
    do_acc(20, 0, PC_G, 3);  expect_pred(0, 20, 0, "R6 setup");
    do_acc(20, 1, PC_G, 3);  expect_pred(0, 20, 0, "R3 add");
    do_ev(20, 1);
    do_acc(21, 10, PC_G, 3); expect_pred(1, 21, b(11), "R6 learned");
    do_ev(21, 10);
    do_acc(22, 10, PC_G, 3); expect_pred(0, 22, 0, "R6 single block erases");

    // R5 sweep over every trigger offset (class 1)
    do_acc(300, 0, PC_S, 1);  expect_pred(0, 300, 0, "R5 setup");
    do_acc(300, 1, PC_S, 1);  expect_pred(0, 300, 0, "R3 add");
    do_acc(300, 63, PC_S, 1); expect_pred(0, 300, 0, "R3 add");
    do_ev(300, 63);
    for (int t = 0; t < 64; t++) begin
      do_acc(400 + t, t, PC_S, 1);
      expect_pred(1, 400 + t, b(t + 1) | b(t + 63), "R5 sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule